// File: doc/BRIEF.md
# Fan Tachometer Edge Counter

This block times one revolution interval of a cooling fan. Up to sixteen tach pins enter through a two-flop synchronizer. A software trigger picks one channel, and the block measures the time between two qualifying edges on that pin. The time is measured in prescaled clock ticks. The block then publishes a result word that holds a done flag and the raw tick count. The RPM arithmetic and the register bus are outside this block. Software writes the trigger value, polls the done flag and converts the count.

Each trigger value is compared with the previous one. A change clears the result and aborts any run in progress. A change to a one-hot value that names an enabled channel starts a new run.

The state machine has five states:
- IDLE: waits for a change of the trigger value.
- ARM: a single cycle that loads the edge detector with the newly selected pin.
- WAIT: looks for the opening edge.
- COUNT: counts ticks until the closing edge.
- DONE: holds the result.

The transitions are:
- start (any state to ARM): the trigger changes to a valid value.
- drop (any state to IDLE): the trigger changes to any other value.
- arm_done (ARM to WAIT).
- open (WAIT to COUNT): the opening qualifying edge.
- close (COUNT to DONE): the closing qualifying edge.
- expire (WAIT or COUNT to DONE): the timeout.

Top module: `tach_meter`

## Requirements
- R1: After reset the result word is zero.
- R2: A change of the trigger value clears the done flag and the count. The change takes effect on the next clock edge and aborts any measurement. A change to a valid value then starts a fresh measurement.
- R3: A trigger value has no effect and done stays 0 in three cases: the value is zero, it has more than one bit set, or it selects a channel whose enable bit is 0.
- R4: `edge_sel` 2'b01 qualifies rising edges and 2'b00 qualifies falling edges. The count is floor(N/P), where N is the number of clocks between two consecutive qualifying edges.
- R5: `edge_sel` 2'b10 qualifies every transition. The measured interval is therefore a half cycle, from one transition to the next.
- R6: The prescale ratio P is 4 << (2·`tach_div`), so the codes give 4, 16, 64 and 256.
- R7: Bit 31 of the result is the done flag. Bits CNT_W-1:0 hold the count (19:0 by default). All other bits are zero.
- R8: A measurement times out if no closing edge arrives within `period_unit`·2^TO_SHIFT ticks of the trigger. On a timeout, done is set with a count of 0. A `period_unit` of 0 times out at once.
- R9: `edge_sel` 2'b11 is reserved. No edge qualifies in this mode, so the measurement can only end through the timeout.
- R10: The count saturates at all ones (0xFFFFF by default) and never wraps.
- R11: Once done is set, the result word stays unchanged until the trigger value changes, even while edges keep arriving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tach_in | input | N_CH | Asynchronous fan tach pins |
| chan_en | input | N_CH | Per-channel enable |
| trig_reg | input | N_CH | Trigger register value; one-hot selects a channel |
| edge_sel | input | 2 | Edge mode: 00 falling, 01 rising, 10 both, 11 reserved |
| tach_div | input | DIV_W | Prescale code d, ratio 4<<(2d) |
| period_unit | input | PERIOD_W | Timeout length in units of 2^TO_SHIFT ticks |
| result | output | 32 | Done in bit 31, count in bits CNT_W-1:0 |

## Verification
A table of tach waveforms drives the counter with different high/low times, channels, edge modes and all four prescale codes. This shows whether the ratio is applied, whether the rising and falling modes measure the full cycle, and whether both-edge mode measures only the high half.

Directed cases cover several things. A disabled channel and a two-hot trigger show that invalid triggers are ignored. Silent pins, a zero period unit and the reserved mode are each run with edges present, which separates timeouts from edge-closed results. A long interval shows saturation. A rewrite in the middle of a measurement shows that it aborts and that the next run measures cleanly. After each result the bench waits while the fan keeps turning, to show the result is held.

// File: rtl/tach_pkg.sv
package tach_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_WAIT  = 3'd2,
        ST_COUNT = 3'd3,
        ST_DONE  = 3'd4
    } meas_state_e;

    localparam logic [1:0] EM_FALL = 2'b00;
    localparam logic [1:0] EM_RISE = 2'b01;
    localparam logic [1:0] EM_BOTH = 2'b10;

endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
    parameter int N_CH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pin_i,
    output logic [N_CH-1:0] sync_o
);
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic stage1_q;
        logic stage2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q <= 1'b0;
                stage2_q <= 1'b0;
            end else begin
                stage1_q <= pin_i[g];
                stage2_q <= stage1_q;
            end
        end
        assign sync_o[g] = stage2_q;
    end
endmodule

// File: rtl/tach_edge_qual.sv
module tach_edge_qual
    import tach_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_i,
    input  logic [1:0] mode_i,
    output logic       qual_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    always_comb begin
        unique case (mode_i)
            EM_FALL: qual_o = prev_q & ~sig_i;
            EM_RISE: qual_o = ~prev_q & sig_i;
            EM_BOTH: qual_o = prev_q ^ sig_i;
            default: qual_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int PC_W = 2 + 2 * ((1 << DIV_W) - 1);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] ratio_m1;

    assign ratio_m1 = (PC_W'(4) << {div_i, 1'b0}) - PC_W'(1);
    assign tick_o   = !restart_i && (pc_q == ratio_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pc_q <= '0;
        else if (restart_i)        pc_q <= '0;
        else if (pc_q == ratio_m1) pc_q <= '0;
        else                       pc_q <= pc_q + PC_W'(1);
    end
endmodule

// File: rtl/tach_meas_fsm.sv
module tach_meas_fsm
    import tach_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int PERIOD_W = 16,
    parameter int TO_SHIFT = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_chg_i,
    input  logic                start_ok_i,
    input  logic                qual_i,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                restart_o,
    output logic                done_o,
    output logic [CNT_W-1:0]    count_o
);
    localparam int TO_W = PERIOD_W + TO_SHIFT;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    meas_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] res_q;
    logic             done_q;
    logic [TO_W-1:0]  tout_q;
    logic [TO_W-1:0]  limit;
    logic             tmo;
    logic             active;

    assign limit  = {period_i, {TO_SHIFT{1'b0}}};
    assign tmo    = (tout_q == limit);
    assign active = (state_q == ST_WAIT) || (state_q == ST_COUNT);

    always_comb begin
        state_d = state_q;
        if (trig_chg_i) begin
            state_d = start_ok_i ? ST_ARM : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARM:   state_d = ST_WAIT;
                ST_WAIT:  if (qual_i) state_d = ST_COUNT;
                          else if (tmo) state_d = ST_DONE;
                ST_COUNT: if (qual_i || tmo) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign restart_o = (trig_chg_i && start_ok_i) ||
                       (!trig_chg_i && state_q == ST_WAIT && qual_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
            tout_q <= '0;
        end else if (trig_chg_i) begin
            cnt_q  <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
            tout_q <= '0;
        end else begin
            if (active && tick_i && !tmo) tout_q <= tout_q + TO_W'(1);
            unique case (state_q)
                ST_WAIT: begin
                    if (qual_i) begin
                        cnt_q <= '0;
                    end else if (tmo) begin
                        res_q  <= '0;
                        done_q <= 1'b1;
                    end
                end
                ST_COUNT: begin
                    if (qual_i) begin
                        res_q  <= (tick_i && cnt_q != CNT_MAX) ? cnt_q + CNT_W'(1) : cnt_q;
                        done_q <= 1'b1;
                    end else if (tmo) begin
                        res_q  <= '0;
                        done_q <= 1'b1;
                    end else if (tick_i && cnt_q != CNT_MAX) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign done_o  = done_q;
    assign count_o = res_q;

    a_r2_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        trig_chg_i |=> (!done_q && res_q == '0));

    a_r3_invalid_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_chg_i && !start_ok_i) |=> (state_q == ST_IDLE && !done_q));

    a_r8_timeout_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && tmo && !qual_i && !trig_chg_i) |=> (done_q && res_q == '0));

    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && cnt_q == CNT_MAX && !trig_chg_i) |=>
        (cnt_q == CNT_MAX || state_q != ST_COUNT));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !trig_chg_i) |=> (done_q && $stable(res_q)));
endmodule

// File: rtl/tach_meter.sv
module tach_meter
    import tach_pkg::*;
#(
    parameter int N_CH     = 16,
    parameter int CNT_W    = 20,
    parameter int PERIOD_W = 16,
    parameter int DIV_W    = 2,
    parameter int TO_SHIFT = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_CH-1:0]     tach_in,
    input  logic [N_CH-1:0]     chan_en,
    input  logic [N_CH-1:0]     trig_reg,
    input  logic [1:0]          edge_sel,
    input  logic [DIV_W-1:0]    tach_div,
    input  logic [PERIOD_W-1:0] period_unit,
    output logic [31:0]         result
);
    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int PAD_W = 31 - CNT_W;

    logic [N_CH-1:0]  synced;
    logic [N_CH-1:0]  trig_q;
    logic             trig_chg;
    logic             start_ok;
    logic [CH_W-1:0]  idx;
    logic [CH_W-1:0]  sel_q;
    logic             qual;
    logic             tick;
    logic             restart;
    logic             done;
    logic [CNT_W-1:0] count;

    tach_sync #(.N_CH(N_CH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(tach_in), .sync_o(synced)
    );

    always_comb begin
        idx = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (trig_reg[i]) idx = CH_W'(i);
        end
    end

    assign trig_chg = (trig_reg != trig_q);
    assign start_ok = $onehot(trig_reg) && |(trig_reg & chan_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= '0;
            sel_q  <= '0;
        end else begin
            trig_q <= trig_reg;
            if (trig_chg && start_ok) sel_q <= idx;
        end
    end

    tach_edge_qual u_qual (
        .clk(clk), .rst_n(rst_n), .sig_i(synced[sel_q]),
        .mode_i(edge_sel), .qual_o(qual)
    );

    tach_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart_i(restart),
        .div_i(tach_div), .tick_o(tick)
    );

    tach_meas_fsm #(.CNT_W(CNT_W), .PERIOD_W(PERIOD_W), .TO_SHIFT(TO_SHIFT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .trig_chg_i(trig_chg), .start_ok_i(start_ok),
        .qual_i(qual), .tick_i(tick), .period_i(period_unit),
        .restart_o(restart), .done_o(done), .count_o(count)
    );

    assign result = {done, {PAD_W{1'b0}}, count};

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result[31]) |-> !trig_chg);
endmodule

// File: tb/sim_tach_meter.sv
module sim_tach_meter;
    localparam int N_CH = 16;
    localparam int CNT_W = 8;

    typedef struct packed {
        int ch; int mode; int div; int hi; int lo; int expv;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{3, 1, 0, 50, 70, 30},
        '{3, 0, 0, 33, 90, 30},
        '{7, 2, 0, 50, 70, 12},
        '{0, 1, 1, 100, 157, 16},
        '{15, 0, 2, 500, 700, 18},
        '{9, 2, 3, 1300, 200, 5},
        '{5, 1, 0, 3, 4, 1}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic [N_CH-1:0] tach_in;
    logic [N_CH-1:0] chan_en = '1;
    logic [N_CH-1:0] trig_reg = '0;
    logic [1:0] edge_sel = 2'b01;
    logic [1:0] tach_div = 2'b00;
    logic [15:0] period_unit = 16'hFFFF;
    logic [31:0] result;

    int checks = 0, errors = 0, cyc = 0;
    bit gen_on = 0; int gen_ch = 0, gen_hi = 10, gen_lo = 10;
    bit gen_lvl = 0; int gcnt = 0;

    always #5 clk = ~clk;

    tach_meter #(.N_CH(N_CH), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .chan_en(chan_en),
        .trig_reg(trig_reg), .edge_sel(edge_sel), .tach_div(tach_div),
        .period_unit(period_unit), .result(result)
    );

    always @(negedge clk) begin
        if (!gen_on) begin gen_lvl = 0; gcnt = 0; end
        else begin
            gcnt++;
            if (!gen_lvl && gcnt >= gen_lo) begin gen_lvl = 1; gcnt = 0; end
            else if (gen_lvl && gcnt >= gen_hi) begin gen_lvl = 0; gcnt = 0; end
        end
    end
    assign tach_in = gen_lvl ? (N_CH'(1) << gen_ch) : '0;

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic check(string req, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_trig(logic [N_CH-1:0] v);
        @(negedge clk); trig_reg = v;
    endtask

    task automatic wait_done(int maxc);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (result[31]) break;
        end
    endtask

    task automatic measure(int ch, int mode, int div, int hi, int lo);
        gen_on = 0; ticks(3);
        edge_sel = 2'(mode); tach_div = 2'(div);
        gen_ch = ch; gen_hi = hi; gen_lo = lo;
        write_trig('0); ticks(2);
        write_trig(N_CH'(1) << ch); ticks(5);
        gen_on = 1;
        wait_done(20000);
    endtask

    initial begin
        ticks(3);
        check("R1 reset result", result, 0);
        rst_n = 1; ticks(2);
        check("R1 result after reset", result, 0);

        // R4 R5 R6 table of waveforms
        foreach (VECS[k]) begin
            logic [31:0] snap;
            measure(VECS[k].ch, VECS[k].mode, VECS[k].div, VECS[k].hi, VECS[k].lo);
            check($sformatf("R4/R5/R6 vec%0d done", k), result[31], 1);
            check($sformatf("R4/R5/R6 vec%0d count", k), result[CNT_W-1:0], VECS[k].expv);
            check($sformatf("R7 vec%0d pad bits", k), result[30:CNT_W], 0);
            snap = result; ticks(300);
            check($sformatf("R11 vec%0d held", k), result, snap);
        end

        // R2: rewrite clears a finished result
        write_trig('0); ticks(1);
        check("R2 clear after rewrite", result, 0);

        // R2: abort mid-measurement then restart
        gen_on = 0; ticks(3);
        edge_sel = 2'b01; tach_div = 0; gen_ch = 2; gen_hi = 200; gen_lo = 200;
        write_trig(N_CH'(1) << 2); ticks(3); gen_on = 1; ticks(250);
        write_trig('0); ticks(600);
        check("R2 aborted run stays not done", result[31], 0);
        write_trig(N_CH'(1) << 2); wait_done(5000);
        check("R2 restart count", result[CNT_W-1:0], 100);

        // R3: disabled channel
        gen_on = 0; write_trig('0); ticks(3);
        chan_en = ~(N_CH'(1) << 4); gen_ch = 4; gen_hi = 20; gen_lo = 20;
        write_trig(N_CH'(1) << 4); gen_on = 1; ticks(300);
        check("R3 disabled channel no done", result[31], 0);
        chan_en = '1;
        // R3: two-hot trigger
        gen_on = 0; write_trig('0); ticks(3); gen_ch = 1;
        write_trig(N_CH'(6)); gen_on = 1; ticks(300);
        check("R3 two-hot trigger no done", result[31], 0);

        // R8: timeout with silent pin
        gen_on = 0; write_trig('0); ticks(3); period_unit = 16'd2;
        write_trig(N_CH'(1) << 1); ticks(150);
        check("R8 not expired early", result[31], 0);
        ticks(250);
        check("R8 timeout done", result[31], 1);
        check("R8 timeout count zero", result[CNT_W-1:0], 0);

        // R8: zero period expires at once
        write_trig('0); ticks(2); period_unit = 0;
        write_trig(N_CH'(1) << 1); ticks(5);
        check("R8 zero period done", result[31], 1);
        check("R8 zero period count", result[CNT_W-1:0], 0);

        // R9: reserved mode ignores edges
        write_trig('0); ticks(2); period_unit = 16'd4; edge_sel = 2'b11;
        gen_ch = 1; gen_hi = 20; gen_lo = 20;
        write_trig(N_CH'(1) << 1); gen_on = 1; ticks(200);
        check("R9 reserved mode not done early", result[31], 0);
        wait_done(2000);
        check("R9 reserved mode times out", result[31], 1);
        check("R9 reserved mode count zero", result[CNT_W-1:0], 0);

        // R10: saturation
        period_unit = 16'hFFFF;
        measure(6, 1, 0, 600, 600);
        check("R10 saturated done", result[31], 1);
        check("R10 saturated count", result[CNT_W-1:0], 255);

        finish_run();
    end
endmodule